// File: doc/BRIEF.md
# Continuous Burst Read Sequencer

This block generates the word address and a data-ready strobe for a synchronous, unbounded burst read out of a word-addressed memory array. The array is assumed to return the word one clock after its address is presented. A burst begins when chip-enable and the address strobe are both low at a rising clock edge, which captures the start address. The sequencer then waits out an initial access latency and issues one word per clock, raising the address by one each time. The address wraps to zero past the top of the space, and the burst runs until chip-enable goes high, reset is applied, or a new start address is captured.

The array is organised in 64-word rows. After the last word of a row (low six address bits all ones) has been issued, the sequencer inserts two dead cycles before moving on. A start address in the last two words of a row is handled in one of two ways, chosen at build time. In the standard handshake the first crossing after such a start has no dead cycles. In the reduced wait-state handshake those two cycles are added to the initial latency instead, and that first crossing is then free. Pulling output-enable high, or write-enable low, while chip-enable is low freezes the sequence at any point. Restoring both lets it carry on from exactly where it stopped.

Top module: `burst_read_seq`

## Requirements
- R1: A rising edge with `ce_n`=0 and `avd_n`=0 captures `addr_in`. In the next cycle `mem_addr` equals the captured address and `rdy` is 0. This holds even when a burst is already in progress, and the capture restarts the sequence.
- R2: Count, from the capture edge, only the edges at which the burst advances (`oe_n`=0 and `we_n`=1). With the defaults, the first word is issued at the 5th such edge. `rdy` is 1 in the cycle after that edge, and `mem_addr` is then the start address plus one.
- R3: In every cycle in which `rdy` is 1, `mem_addr` is one greater than it was in the previous cycle. The issued words are consecutive addresses.
- R4: After a word whose low six address bits are 3Fh is issued, the next two advancing edges issue nothing. `rdy` is 0 and `mem_addr` holds during those two cycles, and only then is the next word issued.
- R5: In the standard variant, a start address whose low six bits are 3Eh or 3Fh keeps the normal initial latency, and the first row crossing of that burst gets no dead cycles. Later crossings do.
- R6: In the reduced wait-state variant, a start address whose low six bits are 3Eh or 3Fh lengthens the initial latency by two edges (7 with defaults), and the first row crossing gets no dead cycles. Every other start offset behaves as in the standard variant.
- R7: After the word at address 7FFFFFh is issued, the next word is address 0 and the burst carries on.
- R8: While `ce_n` is 1 at a rising edge, `rdy` is 0 in the next cycle and the burst is ended. Lowering `ce_n` again without `avd_n` does not restart it.
- R9: A rising edge with `ce_n`=0, `avd_n`=1 and either `oe_n`=1 or `we_n`=0 freezes the sequence. `rdy` is 0 in the next cycle, `mem_addr` is unchanged, and no latency, dead-cycle or word count advances. This applies both during the initial latency and during data output.
- R10: While `rst_n` is 0, `rdy` is 0 and `mem_addr` is 0, and no burst is active afterwards until an address is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; low freezes a burst |
| oe_n | input | 1 | Output enable, active low; high freezes a burst |
| avd_n | input | 1 | Address strobe, active low; captures `addr_in` |
| addr_in | input | AW (23) | Burst start word address |
| mem_addr | output | AW (23) | Word address presented to the array |
| rdy | output | 1 | High in each cycle a valid word is on the array output |

## Verification
The interaction that matters most is a freeze landing on the two dead cycles that follow a row's last word. In that case the dead-cycle count and the freeze both hold `rdy` low, and a design that lets the count run on during the freeze will issue the next row too early. The bench provokes this by starting at 3Ch and pulling `oe_n` high for the three edges right after 3Fh is issued. It also freezes a burst during its initial latency, and it uses `we_n` low as the freeze source once. Every cycle is judged against an expected word count. That count is computed arithmetically from the number of advancing edges since the capture, the start offset and the variant, and both variants run side by side on the same stimulus.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_DATA  = 2'd2,
      ST_STALL = 2'd3
   } bsq_state_t;
endpackage

// File: rtl/bsq_start_cfg.sv
module bsq_start_cfg #(
   parameter int AW           = 23,
   parameter int BB           = 6,
   parameter int INIT_LAT     = 5,
   parameter int STALL_CYC    = 2,
   parameter bit REDUCED_WAIT = 1'b0,
   parameter int LW           = 4
) (
   input  logic [AW-1:0] start,
   output logic [LW-1:0] lat_load,
   output logic          skip_first
);
   logic near_end;
   // last two words of a row: low bits all ones except possibly bit 0
   assign near_end   = &start[BB-1:1];
   assign skip_first = near_end;

   generate
      if (REDUCED_WAIT) begin : g_reduced
         assign lat_load = near_end ? LW'(INIT_LAT + STALL_CYC - 1) : LW'(INIT_LAT - 1);
      end else begin : g_standard
         assign lat_load = LW'(INIT_LAT - 1);
      end
   endgenerate
endmodule

// File: rtl/bsq_addr_ctr.sv
module bsq_addr_ctr #(
   parameter int AW = 23,
   parameter int BB = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] ptr,
   output logic          at_bound
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_val;
      else if (step) ptr <= ptr + 1'b1;
   end

   assign at_bound = &ptr[BB-1:0];
endmodule

// File: rtl/bsq_fsm.sv
module bsq_fsm
   import bsq_pkg::*;
#(
   parameter int LW        = 4,
   parameter int STALL_CYC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stop,
   input  logic          latch,
   input  logic          hold,
   input  logic [LW-1:0] lat_load,
   input  logic          skip_first,
   input  logic          at_bound,
   output logic          step,
   output logic          rdy
);
   bsq_state_t    state_q;
   logic [LW-1:0] cnt_q;
   logic          skip_q;
   logic          issue;

   assign issue = (state_q == ST_DATA) || ((state_q == ST_WAIT) && (cnt_q == '0));
   assign step  = issue && !stop && !latch && !hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         skip_q  <= 1'b0;
         rdy     <= 1'b0;
      end else begin
         rdy <= step;
         if (stop) begin
            state_q <= ST_IDLE;
         end else if (latch) begin
            state_q <= ST_WAIT;
            cnt_q   <= lat_load;
            skip_q  <= skip_first;
         end else if (!hold) begin
            if (step) begin
               if (at_bound) begin
                  skip_q <= 1'b0;
                  if (!skip_q) begin
                     state_q <= ST_STALL;
                     cnt_q   <= LW'(STALL_CYC - 1);
                  end else begin
                     state_q <= ST_DATA;
                  end
               end else begin
                  state_q <= ST_DATA;
               end
            end else if (state_q == ST_WAIT) begin
               cnt_q <= cnt_q - 1'b1;
            end else if (state_q == ST_STALL) begin
               if (cnt_q == '0) state_q <= ST_DATA;
               else             cnt_q   <= cnt_q - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq #(
   parameter int AW           = 23,
   parameter int BB           = 6,
   parameter int INIT_LAT     = 5,
   parameter int STALL_CYC    = 2,
   parameter bit REDUCED_WAIT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic          avd_n,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] mem_addr,
   output logic          rdy
);
   localparam int LW = $clog2(INIT_LAT + STALL_CYC + 2);

   generate
      if (INIT_LAT < 1)  begin : g_bad_lat   $error("INIT_LAT must be at least 1"); end
      if (STALL_CYC < 1) begin : g_bad_stall $error("STALL_CYC must be at least 1"); end
      if (BB < 2 || BB >= AW) begin : g_bad_bb $error("BB must lie in 2..AW-1"); end
   endgenerate

   logic          latch, stop, hold, step, skip_first, at_bound;
   logic [LW-1:0] lat_load;

   assign stop  = ce_n;
   assign latch = !ce_n && !avd_n;
   assign hold  = oe_n || !we_n;

   bsq_start_cfg #(
      .AW(AW), .BB(BB), .INIT_LAT(INIT_LAT), .STALL_CYC(STALL_CYC),
      .REDUCED_WAIT(REDUCED_WAIT), .LW(LW)
   ) u_cfg (
      .start(addr_in), .lat_load(lat_load), .skip_first(skip_first)
   );

   bsq_addr_ctr #(.AW(AW), .BB(BB)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(latch), .load_val(addr_in),
      .step(step), .ptr(mem_addr), .at_bound(at_bound)
   );

   bsq_fsm #(.LW(LW), .STALL_CYC(STALL_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .stop(stop), .latch(latch), .hold(hold),
      .lat_load(lat_load), .skip_first(skip_first), .at_bound(at_bound),
      .step(step), .rdy(rdy)
   );
endmodule

// File: rtl/bsq_chk.sv
module bsq_chk #(
   parameter int AW = 23
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ce_n,
   input logic          we_n,
   input logic          oe_n,
   input logic          avd_n,
   input logic [AW-1:0] addr_in,
   input logic [AW-1:0] mem_addr,
   input logic          rdy
);
   p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !avd_n) |=> (!rdy && mem_addr == $past(addr_in)));

   p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

   p_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> !rdy);

   p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && avd_n && (oe_n || !we_n)) |=> (!rdy && $stable(mem_addr)));

   always_comb begin
      if (!rst_n) begin
         p_reset_r10: assert (!rdy && mem_addr == '0);
      end
   end
endmodule

bind burst_read_seq bsq_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
   .avd_n(avd_n), .addr_in(addr_in), .mem_addr(mem_addr), .rdy(rdy)
);

// File: tb/sim_burst_read_seq.sv
module sim_burst_read_seq;
   localparam int AW   = 23;
   localparam int LAT  = 5;
   localparam int GAP  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, avd_n = 1'b1;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] ma0, ma1;
   logic          rd0, rd1;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   burst_read_seq #(.REDUCED_WAIT(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .avd_n(avd_n), .addr_in(addr_in), .mem_addr(ma0), .rdy(rd0));

   burst_read_seq #(.REDUCED_WAIT(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .avd_n(avd_n), .addr_in(addr_in), .mem_addr(ma1), .rdy(rd1));

   function automatic int lat_of(bit red, int off);
      return LAT + ((red && off >= 62) ? GAP : 0);
   endfunction

   // advancing edge index at which word j is issued
   function automatic int edge_of(bit red, int off, int j);
      int crossings, stalled;
      crossings = (off + j) / 64;
      stalled   = crossings - ((off >= 62 && crossings > 0) ? 1 : 0);
      return lat_of(red, off) + j + GAP * stalled;
   endfunction

   function automatic int words_by(bit red, int off, int c);
      int n = 0;
      while (edge_of(red, off, n) <= c) n++;
      return n;
   endfunction

   task automatic chk_bit(string tag, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic chk_addr(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic capture(int a);
      @(negedge clk);
      addr_in = AW'(a); ce_n = 1'b0; avd_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      avd_n = 1'b1;
      chk_bit ("R1", "rdy after capture std", rd0, 1'b0);
      chk_bit ("R1", "rdy after capture red", rd1, 1'b0);
      chk_addr("R1", "addr after capture std", ma0, AW'(a));
      chk_addr("R1", "addr after capture red", ma1, AW'(a));
   endtask

   // run a burst from a; freeze edges [fz_at, fz_at+fz_len), via we_n if use_we
   task automatic burst(int a, int ncyc, int fz_at, int fz_len, bit use_we);
      int off, c;
      off = a % 64;
      c = 0;
      capture(a);
      for (int k = 0; k < ncyc; k++) begin
         bit act;
         act  = !(k >= fz_at && k < fz_at + fz_len);
         oe_n = act ? 1'b0 : !use_we;
         we_n = act ? 1'b1 : !use_we;
         @(posedge clk);
         @(negedge clk);
         if (act) c++;
         for (int v = 0; v < 2; v++) begin
            bit red;
            int wn, wp;
            string tr, ta;
            logic exp_r;
            red = (v == 1);
            wn  = words_by(red, off, c);
            wp  = (c > 0) ? words_by(red, off, c - 1) : 0;
            exp_r = act && (wn > wp);
            if (!act)                    tr = "R9";
            else if (red && off >= 62)   tr = "R6";
            else if (off >= 62)          tr = "R5";
            else if (c <= LAT)           tr = "R2";
            else                         tr = "R4";
            ta = (a + wn >= (1 << AW)) ? "R7" : "R3";
            if (v == 0) begin
               chk_bit (tr, "rdy std", rd0, exp_r);
               chk_addr(ta, "addr std", ma0, AW'(a + wn));
            end else begin
               chk_bit (tr, "rdy red", rd1, exp_r);
               chk_addr(ta, "addr red", ma1, AW'(a + wn));
            end
         end
      end
      oe_n = 1'b0; we_n = 1'b1;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      chk_bit ("R10", "rdy in reset std", rd0, 1'b0);
      chk_bit ("R10", "rdy in reset red", rd1, 1'b0);
      chk_addr("R10", "addr in reset std", ma0, '0);
      chk_addr("R10", "addr in reset red", ma1, '0);
      rst_n = 1'b1;
      ce_n  = 1'b0; oe_n = 1'b0;
      repeat (3) @(negedge clk);
      chk_bit("R10", "idle after reset std", rd0, 1'b0);
      chk_bit("R10", "idle after reset red", rd1, 1'b0);

      // sweep every row offset; each burst is restarted mid-flight by the next (R1)
      for (int off = 0; off < 64; off++) burst(32'h123540 + off, 80, 1000, 0, 1'b0);

      // R7: wrap at the top of the space, with and without a skipped crossing
      burst(32'h7FFFFE, 40, 1000, 0, 1'b0);
      burst(32'h7FFFC5, 80, 1000, 0, 1'b0);

      // R9: freeze during latency, during a row-crossing gap, and via we_n
      burst(32'h000010, 30, 2, 4, 1'b0);
      burst(32'h00003C, 30, 8, 3, 1'b0);
      burst(32'h00003D, 30, 9, 2, 1'b1);
      burst(32'h00023E, 90, 20, 5, 1'b0);

      // R8: chip enable high ends the burst; lowering it again does not restart
      burst(32'h000100, 10, 1000, 0, 1'b0);
      ce_n = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); @(negedge clk);
         chk_bit("R8", "rdy with ce_n high std", rd0, 1'b0);
         chk_bit("R8", "rdy with ce_n high red", rd1, 1'b0);
      end
      ce_n = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(posedge clk); @(negedge clk);
         chk_bit("R8", "no restart std", rd0, 1'b0);
         chk_bit("R8", "no restart red", rd1, 1'b0);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule